// File: doc/BRIEF.md
# Serial Shift Slice with Shadow Word Exchange

The block is one lane of a serial I/O engine. A data word register shifts one bit per shift tick: the serial input enters at the most significant bit and the least significant bit drives the serial output. A programmable prescaler sets the shift tick rate. A bit-position counter sets the word length. When a word completes, the freshly shifted word moves into a shadow register and the old shadow contents move into the data register. Software then reads the captured word and writes the next outgoing word into the shadow register. A word with a single set bit, such as 0x40000000, gives one high bit on the serial output, which can serve as a DMA request pulse.

In pattern-match mode the shadow register holds a compare pattern instead of the next word. After every shift the block compares the data register with that pattern, and a mask excludes selected bit positions from the comparison. While match mode and its event enable are both set, the word exchange is held off so the pattern is kept. The slice gives a one-cycle event pulse for each shift, each exchange and each match.

A two-state controller governs the slice. In state IDLE the prescaler and position counter are loaded continuously from their programmed values. Nothing shifts in IDLE. The transition START (IDLE to RUN) is taken when `run` is high. In state RUN the counters are active. The transition HALT (RUN to IDLE) is taken when `run` goes low, and no shift happens in that cycle.

Top module: `ser_slice`

## Requirements
- R1: After reset the data register, shadow register, serial output and all three event outputs are 0, and the controller is in IDLE.
- R2: In IDLE, and in any cycle where `run` is low, no shift takes place. The prescaler is loaded with `tick_reload` and the position counter with `word_bits`−1. The START transition takes one cycle, so shifting counts down from the next cycle on.
- R3: In RUN a shift happens once every `tick_reload`+1 cycles. `evt_shift` is high for exactly the cycle after the clock edge where that shift happened.
- R4: On a shift the data register becomes {`ser_in`, data[W−1:1]}. `ser_out` always equals data bit 0.
- R5: Every `word_bits` shifts (valid range 1..W), in the shift where the position counter is 0, the shifted word goes into the shadow register and the old shadow value goes into the data register. `evt_swap` pulses together with that `evt_shift`.
- R6: `shd_rd_data` shows the shadow register. A write with `shd_wr_en` sets the shadow register on the next edge. If a write and an exchange fall in the same cycle, the written value wins in the shadow register, and the data register still receives the old shadow value.
- R7: When `match_mode` and `match_irq_en` are both 1, `evt_match` pulses with the shift whose resulting data word equals the shadow register in every bit where `match_mask` is 0. A mask bit of 1 excludes that position from the comparison.
- R8: While `match_mode` and `match_irq_en` are both 1, no exchange occurs and `evt_swap` stays 0. The position counter still wraps, and the shift result stays in the data register.
- R9: When only one of `match_mode` and `match_irq_en` is set, `evt_match` stays 0 and exchanges proceed as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Run request; high selects RUN |
| tick_reload | input | PRE_W | Prescaler reload; shift period is value+1 cycles |
| word_bits | input | POS_W | Bits per word, 1..DATA_W |
| ser_in | input | 1 | Serial input bit |
| ser_out | output | 1 | Serial output bit (data bit 0) |
| shd_wr_en | input | 1 | Shadow register write strobe |
| shd_wr_data | input | DATA_W | Shadow register write value |
| shd_rd_data | output | DATA_W | Shadow register contents |
| match_mode | input | 1 | Pattern-match mode select |
| match_irq_en | input | 1 | Pattern-match event enable |
| match_mask | input | DATA_W | 1 = bit excluded from comparison |
| evt_shift | output | 1 | Shift event pulse |
| evt_swap | output | 1 | Exchange event pulse |
| evt_match | output | 1 | Pattern match event pulse |

## Verification
The bench builds the slice with DATA_W=32 and a narrow PRE_W=4. This keeps every shift period within 16 cycles, so many full words and exchanges fit in a short run. The full 32-bit width keeps the single-bit request pattern 0x40000000 and the full-width comparison reachable. Word lengths of 1, 4, 8 and 32 and randomly drawn values expose the wrap of the position counter at both ends of its range. They also bring an exchange into the same cycle as a software write to the shadow register.

// File: rtl/ser_slice_pkg.sv
package ser_slice_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } slice_st_e;
endpackage

// File: rtl/ser_slice_tick.sv
module ser_slice_tick #(
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             active,
    input  logic [PRE_W-1:0] reload,
    output logic             tick
);
    logic [PRE_W-1:0] cnt_q;

    assign tick = active && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= reload;
        end else if (active) begin
            if (cnt_q == '0) cnt_q <= reload;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    // R3: after a tick the prescaler restarts from the reload value
    p_reload_after_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> cnt_q == $past(reload));

    // R2: counter is frozen while neither loading nor active
    p_hold_when_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !active) |=> $stable(cnt_q));
endmodule

// File: rtl/ser_slice_pos.sv
module ser_slice_pos #(
    parameter int POS_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [POS_W-1:0] word_bits,
    output logic             wrap
);
    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] last_pos;

    assign last_pos = word_bits - POS_W'(1);
    assign wrap     = step && (pos_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (load) begin
            pos_q <= last_pos;
        end else if (step) begin
            if (pos_q == '0) pos_q <= last_pos;
            else             pos_q <= pos_q - 1'b1;
        end
    end

    // R5: a word boundary restarts the position count at word_bits-1
    p_wrap_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> pos_q == $past(last_pos));

    // R2: without load or step the position does not move
    p_pos_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(pos_q));
endmodule

// File: rtl/ser_slice_cmp.sv
module ser_slice_cmp #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] word,
    input  logic [DATA_W-1:0] pattern,
    input  logic [DATA_W-1:0] mask,
    output logic              hit
);
    logic [DATA_W-1:0] diff;

    assign diff = (word ^ pattern) & ~mask;
    assign hit  = (diff == '0);
endmodule

// File: rtl/ser_slice.sv
module ser_slice
    import ser_slice_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PRE_W  = 12,
    localparam int POS_W = $clog2(DATA_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [PRE_W-1:0]  tick_reload,
    input  logic [POS_W-1:0]  word_bits,
    input  logic              ser_in,
    output logic              ser_out,
    input  logic              shd_wr_en,
    input  logic [DATA_W-1:0] shd_wr_data,
    output logic [DATA_W-1:0] shd_rd_data,
    input  logic              match_mode,
    input  logic              match_irq_en,
    input  logic [DATA_W-1:0] match_mask,
    output logic              evt_shift,
    output logic              evt_swap,
    output logic              evt_match
);
    slice_st_e         state_q, state_d;
    logic [DATA_W-1:0] data_q, shadow_q;
    logic [DATA_W-1:0] shifted;
    logic              active, load_cnt;
    logic              tick, wrap, hit;
    logic              match_on, do_swap;

    // ---------------- controller ----------------
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = run ? ST_RUN : ST_IDLE;   // START
            ST_RUN:  state_d = run ? ST_RUN : ST_IDLE;   // HALT
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign load_cnt = (state_q == ST_IDLE);
    assign active   = (state_q == ST_RUN) && run;

    // ---------------- counters ----------------
    ser_slice_tick #(.PRE_W(PRE_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load_cnt),
        .active (active),
        .reload (tick_reload),
        .tick   (tick)
    );

    ser_slice_pos #(.POS_W(POS_W)) u_pos (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_cnt),
        .step      (tick),
        .word_bits (word_bits),
        .wrap      (wrap)
    );

    // ---------------- datapath ----------------
    assign shifted  = {ser_in, data_q[DATA_W-1:1]};
    assign match_on = match_mode && match_irq_en;
    assign do_swap  = wrap && !match_on;

    ser_slice_cmp #(.DATA_W(DATA_W)) u_cmp (
        .word    (shifted),
        .pattern (shadow_q),
        .mask    (match_mask),
        .hit     (hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q   <= '0;
            shadow_q <= '0;
        end else begin
            if (tick) data_q <= do_swap ? shadow_q : shifted;
            if (shd_wr_en)    shadow_q <= shd_wr_data;
            else if (do_swap) shadow_q <= shifted;
        end
    end

    // ---------------- event outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_shift <= 1'b0;
            evt_swap  <= 1'b0;
            evt_match <= 1'b0;
        end else begin
            evt_shift <= tick;
            evt_swap  <= do_swap;
            evt_match <= tick && match_on && hit;
        end
    end

    assign ser_out     = data_q[0];
    assign shd_rd_data = shadow_q;

    // ---------------- assertions ----------------
    // R5: an exchange always coincides with a shift
    p_swap_with_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_swap |-> evt_shift);

    // R7: a match is only reported on a shift
    p_match_with_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_match |-> evt_shift);

    // R8: exchange held off while match mode and its enable are set
    p_no_swap_in_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(match_mode && match_irq_en) |-> !evt_swap);

    // R9: no match event unless both match controls were set
    p_match_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(match_mode && match_irq_en) |-> !evt_match);

    // R2: no shift event while idle
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !evt_shift);

    // R6: a write always lands in the shadow register
    p_write_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        shd_wr_en |=> shd_rd_data == $past(shd_wr_data));
endmodule

// File: tb/ser_slice_tb_top.sv
module ser_slice_tb_top;
    localparam int DW    = 32;
    localparam int PW    = 4;
    localparam int POSW  = $clog2(DW) + 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            run = 1'b0;
    logic [PW-1:0]   tick_reload = '0;
    logic [POSW-1:0] word_bits = POSW'(DW);
    logic            ser_in = 1'b0;
    logic            ser_out;
    logic            shd_wr_en = 1'b0;
    logic [DW-1:0]   shd_wr_data = '0;
    logic [DW-1:0]   shd_rd_data;
    logic            match_mode = 1'b0;
    logic            match_irq_en = 1'b0;
    logic [DW-1:0]   match_mask = '0;
    logic            evt_shift, evt_swap, evt_match;

    always #2 clk = ~clk;   // 250 MHz

    ser_slice #(.DATA_W(DW), .PRE_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .run(run), .tick_reload(tick_reload),
        .word_bits(word_bits), .ser_in(ser_in), .ser_out(ser_out),
        .shd_wr_en(shd_wr_en), .shd_wr_data(shd_wr_data), .shd_rd_data(shd_rd_data),
        .match_mode(match_mode), .match_irq_en(match_irq_en), .match_mask(match_mask),
        .evt_shift(evt_shift), .evt_swap(evt_swap), .evt_match(evt_match)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    string sw_tag = "R5";
    string mt_tag = "R7";

    // reference state
    bit          m_run;
    int          m_pre, m_pos;
    logic [DW-1:0] m_data, m_shd;
    bit          e_sh, e_sw, e_mt;
    int          dut_matches, mdl_matches, mdl_swaps;

    function automatic logic [DW-1:0] masked_diff(logic [DW-1:0] a, logic [DW-1:0] b,
                                                  logic [DW-1:0] m);
        return (a ^ b) & ~m;
    endfunction

    task automatic model_step();
        logic [DW-1:0] sh, nshd;
        bit both;
        e_sh = 0; e_sw = 0; e_mt = 0;
        if (!rst_n) begin
            m_run = 0; m_pre = 0; m_pos = 0; m_data = '0; m_shd = '0;
        end else begin
            both = match_mode && match_irq_en;
            nshd = m_shd;
            if (!m_run) begin
                m_pre = int'(tick_reload);
                m_pos = int'(word_bits) - 1;
            end else if (run) begin
                if (m_pre == 0) begin
                    m_pre = int'(tick_reload);
                    e_sh  = 1;
                    sh    = {ser_in, m_data[DW-1:1]};
                    if (both && masked_diff(sh, m_shd, match_mask) == '0) e_mt = 1;
                    if (m_pos == 0) begin
                        m_pos = int'(word_bits) - 1;
                        if (!both) begin
                            e_sw = 1; nshd = sh; m_data = m_shd;
                        end else m_data = sh;
                    end else begin
                        m_pos--; m_data = sh;
                    end
                end else m_pre--;
            end
            if (shd_wr_en) nshd = shd_wr_data;
            m_shd = nshd;
            m_run = run;
        end
    endtask

    task automatic check(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check(ser_out == m_data[0], "R4", "ser_out", DW'(ser_out), DW'(m_data[0]));
        check(evt_shift == e_sh, "R3", "evt_shift", DW'(evt_shift), DW'(e_sh));
        check(evt_swap == e_sw, sw_tag, "evt_swap", DW'(evt_swap), DW'(e_sw));
        check(evt_match == e_mt, mt_tag, "evt_match", DW'(evt_match), DW'(e_mt));
        check(shd_rd_data == m_shd, "R6", "shd_rd_data", shd_rd_data, m_shd);
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
        if (evt_match) dut_matches++;
        if (e_mt) mdl_matches++;
        if (e_sw) mdl_swaps++;
    endtask

    task automatic run_cycles(int n, bit rnd_in);
        for (int i = 0; i < n; i++) begin
            if (rnd_in) ser_in = 1'($urandom);
            cyc();
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        m_run = 0; m_pre = 0; m_pos = 0; m_data = '0; m_shd = '0;
        dut_matches = 0; mdl_matches = 0; mdl_swaps = 0;

        // R1: reset state
        repeat (3) cyc();
        @(negedge clk);
        rst_n = 1'b1;
        check(ser_out == 1'b0 && evt_shift == 1'b0 && evt_swap == 1'b0 && evt_match == 1'b0,
              "R1", "reset events", DW'({ser_out, evt_shift, evt_swap, evt_match}), '0);
        check(shd_rd_data == '0, "R1", "reset shadow", shd_rd_data, '0);

        // R2: idle, nothing shifts
        tick_reload = '0;
        run_cycles(6, 1);

        // R3/R4/R5: request pattern preloaded, full word length
        shd_wr_en = 1; shd_wr_data = 32'h4000_0000; cyc(); shd_wr_en = 0;
        tick_reload = 4'd2; word_bits = POSW'(32); run = 1;
        ser_in = 0;
        run_cycles(3 * 32 + 4, 0);
        check(mdl_swaps > 0, "R5", "exchange reached", DW'(mdl_swaps), 1);
        run_cycles(3 * 40, 1);

        // R2: halt mid-word, counters reload
        run = 0; run_cycles(5, 1);
        run = 1; run_cycles(20, 1);

        // R6: writes coinciding with exchanges, short words incl. length 1
        tick_reload = '0; run = 0; cyc();
        word_bits = POSW'(1); run = 1;
        for (int i = 0; i < 12; i++) begin
            shd_wr_en = 1'($urandom); shd_wr_data = $urandom; ser_in = 1'($urandom); cyc();
        end
        word_bits = POSW'(4);
        for (int i = 0; i < 24; i++) begin
            shd_wr_en = 1'($urandom); shd_wr_data = $urandom; ser_in = 1'($urandom); cyc();
        end
        shd_wr_en = 0;

        // R8: exchange blocked in match mode
        sw_tag = "R8"; match_mode = 1; match_irq_en = 1; match_mask = '1;
        mdl_swaps = 0;
        run_cycles(40, 1);
        check(mdl_swaps == 0, "R8", "no model exchange", DW'(mdl_swaps), 0);

        // R9: only one control set
        sw_tag = "R9"; mt_tag = "R9";
        match_irq_en = 0; run_cycles(20, 1);
        match_mode = 0; match_irq_en = 1; run_cycles(20, 1);

        // R7: pattern A5 in low byte, upper bits masked out
        sw_tag = "R5"; mt_tag = "R7";
        run = 0; match_mode = 1; match_irq_en = 1; match_mask = 32'hFFFF_FF00;
        shd_wr_en = 1; shd_wr_data = 32'h0000_00A5; cyc(); shd_wr_en = 0;
        word_bits = POSW'(8); tick_reload = 4'd1; run = 1; cyc();
        mdl_matches = 0; dut_matches = 0;
        for (int i = 0; i < 2 * 56; i++) begin
            ser_in = 1'((8'hA5 >> ((i / 2) % 8)) & 8'h01);
            cyc();
        end
        check(mdl_matches > 0, "R7", "model matches", DW'(mdl_matches), 1);
        check(dut_matches == mdl_matches, "R7", "match count", DW'(dut_matches), DW'(mdl_matches));

        // mixed random traffic
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 50) == 0) run = ~run;
            if (($urandom % 200) == 0) tick_reload = PW'($urandom);
            if (($urandom % 150) == 0) word_bits = POSW'(1 + ($urandom % DW));
            if (($urandom % 300) == 0) begin
                match_mode = 1'($urandom); match_irq_en = 1'($urandom);
                match_mask = ($urandom % 2) ? 32'hFFFF_FFF0 : '0;
            end
            sw_tag = (match_mode && match_irq_en) ? "R8" : "R5";
            mt_tag = (match_mode && match_irq_en) ? "R7" : "R9";
            shd_wr_en = (($urandom % 8) == 0);
            shd_wr_data = ($urandom % 2) ? $urandom : {28'h0, 4'($urandom)};
            ser_in = 1'($urandom);
            cyc();
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule